// File: doc/BRIEF.md
# Multi-Source Reset Domain Controller

This block turns a set of reset sources into three separate active-low reset outputs: one for the core logic, one for the physical layer of a serial link, and one for the sticky configuration bits. Two sources are asynchronous active-low pins, a power-on pin and a warm pin. Four sources are synchronous single-bit requests raised by the link logic: hot reset, loopback, disable link and link down. Each source clears its own set of domains. The link requests are honoured only when the device runs as an endpoint and its link interface is enabled.

The pin resets assert the affected outputs asynchronously. The link requests assert them on the next clock edge. Every output releases through a two-stage synchroniser. A link request keeps its reset asserted for at least a fixed number of cycles, even when the request lasts only one cycle. The block also holds a vector of strap inputs. A pin reset reloads the whole vector when it ends. A link-derived reset reloads only the bits that a parameter mask selects. A one-hot cause register records which source produced the most recent reset.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst_n`, `phy_rst_n` and `sticky_rst_n` are all low and `rst_cause` reads the power-on code 6'b000001.
- R2: While `warm_n` is low, `core_rst_n` and `phy_rst_n` are low and `sticky_rst_n` stays high.
- R3: After a pin reset is released, the affected outputs are still low after the first rising clock edge and are high after the second.
- R4: A hot-reset, loopback or disable-link request pulls only `core_rst_n` low. `phy_rst_n` and `sticky_rst_n` stay high.
- R5: A link-down request pulls `core_rst_n` and `phy_rst_n` low. `sticky_rst_n` stays high.
- R6: A link request is ignored unless `endpoint_mode` and `link_enable` are both 1. An ignored request changes no reset output, does not change `rst_cause` and does not change `strap_q`.
- R7: A request that is high for L clock edges keeps each affected output low for exactly L+STRETCH_CYC cycles, starting at the first edge after the request is first sampled (STRETCH_CYC defaults to 16).
- R8: On release of either pin reset, `strap_q` loads the whole of `strap_in`.
- R9: When a link-derived reset ends, `strap_q` bits whose position is set in RECAP_MASK (default 8'h0F) reload from `strap_in`. All other bits keep their previous value.
- R10: `rst_cause` is one-hot: bit 0 power-on, bit 1 warm, bit 2 hot reset, bit 3 loopback, bit 4 disable link, bit 5 link down. Power-on takes priority over warm. When several link requests arrive in the same cycle, the highest bit number wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to which every release is synchronised |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_n | input | 1 | Asynchronous warm reset, active low |
| link_hot_req | input | 1 | Hot-reset request from the link, synchronous |
| link_loop_req | input | 1 | Loopback request from the link, synchronous |
| link_dis_req | input | 1 | Disable-link request from the link, synchronous |
| link_down_req | input | 1 | Link-down event, synchronous |
| endpoint_mode | input | 1 | 1 when the device runs as an endpoint |
| link_enable | input | 1 | 1 when the link interface is enabled |
| strap_in | input | STRAP_W | Strap pins to be latched |
| core_rst_n | output | 1 | Core domain reset, active low |
| phy_rst_n | output | 1 | Physical-layer domain reset, active low |
| sticky_rst_n | output | 1 | Sticky-bit domain reset, active low |
| strap_q | output | STRAP_W | Latched strap values |
| rst_cause | output | 6 | One-hot cause of the most recent reset |

## Verification
The bench drives every link source through every combination of the endpoint and enable flags, using several pulse lengths. For each case it counts the low cycles on each domain output and compares the count with L+16, or with zero. A design that ignored the gating would reset the core when the link is disabled. A design that reloaded its stretch counter wrongly would be off by one cycle. A design that routed link down to the wrong domain would leave the physical layer running, or would reset the sticky domain.

A fresh strap pattern is applied before every case. A design that reloaded the whole vector on a link exit would disturb the upper bits, and one that loaded straps on a gated request would show the new pattern. Further checks cover simultaneous link requests, to confirm the cause priority, and a warm reset, to confirm that the sticky domain stays untouched and that the release takes two stages.

// File: rtl/rdc_pkg.sv
// Package: shared indices and types for the reset domain controller.
// Assumes six reset causes and three reset domains, as fixed below.
package rdc_pkg;
    localparam int NUM_LINK = 4;
    localparam int NUM_DOM  = 3;
    localparam int CAUSE_W  = 6;

    // Link source order; a higher index wins when requests coincide.
    localparam int LK_HOT  = 0;
    localparam int LK_LOOP = 1;
    localparam int LK_DIS  = 2;
    localparam int LK_DOWN = 3;

    // Bit positions inside the cause register.
    localparam int C_POR   = 0;
    localparam int C_WARM  = 1;
    localparam int C_LINK0 = 2;

    // Domain indices.
    localparam int D_CORE   = 0;
    localparam int D_PHY    = 1;
    localparam int D_STICKY = 2;

    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/rdc_link_stretch.sv
// Module: rdc_link_stretch
// Turns a gated, synchronous link request into a reset-active flag.
// The flag stays high for STRETCH cycles after the last cycle of the request.
// Assumes that req_i is already qualified by the mode flags and is
// synchronous to clk.
module rdc_link_stretch #(
    parameter int STRETCH = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic req_i,
    output logic active_o
);
    localparam int CW = $clog2(STRETCH + 1);

    logic [CW-1:0] cnt_q;

    // Load the full window on a request, then count down to zero.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            cnt_q <= '0;
        else if (req_i)
            cnt_q <= CW'(STRETCH);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);

    AST_REQ_STARTS_WINDOW: assert property (@(posedge clk) disable iff (!arst_n)
        req_i |=> active_o); // R7
endmodule

// File: rtl/rdc_rst_sync.sv
// Module: rdc_rst_sync
// Reset synchroniser for one domain. The output asserts asynchronously from
// arst_n, or synchronously from srst_i, and releases through two flops.
// Assumes that srst_i is synchronous to clk.
module rdc_rst_sync (
    input  logic clk,
    input  logic arst_n,
    input  logic srst_i,
    output logic rst_n_o
);
    logic s1_q, s2_q;

    // Two-stage release chain, cleared by either reset path.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else if (srst_i) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= 1'b1;
            s2_q <= s1_q;
        end
    end

    assign rst_n_o = s2_q;

    AST_SRST_ASSERTS: assert property (@(posedge clk) disable iff (!arst_n)
        srst_i |=> !rst_n_o); // R7
    AST_TWO_STAGE_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_o) |-> $past(!srst_i, 2)); // R3
endmodule

// File: rtl/rdc_strap_latch.sv
// Module: rdc_strap_latch
// Holds the strap vector. The first edge after a pin reset releases loads
// every bit. A link-exit pulse reloads only the bits set in MASK.
// Assumes that the strap inputs are stable around the capture edges.
module rdc_strap_latch #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    MASK = 8'h0F
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         link_exit_i,
    input  logic [W-1:0] strap_i,
    output logic [W-1:0] strap_o
);
    logic         pin_hold_q;
    logic [W-1:0] strap_q;

    // Flag that is set during a pin reset and clears on the first edge after.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            pin_hold_q <= 1'b1;
        else
            pin_hold_q <= 1'b0;
    end

    // Full capture after a pin reset; masked recapture on a link exit.
    always_ff @(posedge clk) begin
        if (pin_hold_q)
            strap_q <= strap_i;
        else if (link_exit_i)
            strap_q <= (strap_q & ~MASK) | (strap_i & MASK);
    end

    assign strap_o = strap_q;

    AST_RETAINED_STRAPS: assert property (@(posedge clk) disable iff (!arst_n)
        !pin_hold_q |=> ((strap_q & ~MASK) == ($past(strap_q) & ~MASK))); // R9
endmodule

// File: rtl/rst_domain_ctrl.sv
// Module: rst_domain_ctrl (top)
// Combines the power-on pin, the warm pin and four link requests into
// separate reset outputs for the core, physical-layer and sticky domains.
// It also latches the straps and records the reset cause.
// Assumes that the link requests are synchronous to clk and that the pins
// may change at any time.
module rst_domain_ctrl #(
    parameter int                  STRAP_W     = 8,
    parameter logic [STRAP_W-1:0]  RECAP_MASK  = 8'h0F,
    parameter int                  STRETCH_CYC = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               warm_n,
    input  logic               link_hot_req,
    input  logic               link_loop_req,
    input  logic               link_dis_req,
    input  logic               link_down_req,
    input  logic               endpoint_mode,
    input  logic               link_enable,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               core_rst_n,
    output logic               phy_rst_n,
    output logic               sticky_rst_n,
    output logic [STRAP_W-1:0] strap_q,
    output logic [5:0]         rst_cause
);
    import rdc_pkg::*;

    logic                pin_n;
    logic [NUM_LINK-1:0] link_req, link_valid, link_act;
    logic                link_any, link_any_d, link_exit;
    logic [NUM_DOM-1:0]  dom_arst_n, dom_srst, dom_rst_n;
    logic                warm_hold_q;
    cause_t              cause_q, link_pick;

    assign pin_n      = por_n & warm_n;
    assign link_req   = {link_down_req, link_dis_req, link_loop_req, link_hot_req};
    assign link_valid = link_req & {NUM_LINK{endpoint_mode & link_enable}};

    // One window stretcher per link source.
    for (genvar g = 0; g < NUM_LINK; g++) begin : g_link
        rdc_link_stretch #(.STRETCH(STRETCH_CYC)) u_stretch (
            .clk      (clk),
            .arst_n   (pin_n),
            .req_i    (link_valid[g]),
            .active_o (link_act[g])
        );
    end

    assign link_any = |link_act;

    // Delayed copy of the combined link window, used to detect its end.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n)
            link_any_d <= 1'b0;
        else
            link_any_d <= link_any;
    end

    assign link_exit = link_any_d & ~link_any;

    // Map the sources onto the domains.
    assign dom_arst_n[D_CORE]   = pin_n;
    assign dom_srst[D_CORE]     = link_any;
    assign dom_arst_n[D_PHY]    = pin_n;
    assign dom_srst[D_PHY]      = link_act[LK_DOWN];
    assign dom_arst_n[D_STICKY] = por_n;
    assign dom_srst[D_STICKY]   = 1'b0;

    // One synchroniser per domain.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        rdc_rst_sync u_sync (
            .clk     (clk),
            .arst_n  (dom_arst_n[d]),
            .srst_i  (dom_srst[d]),
            .rst_n_o (dom_rst_n[d])
        );
    end

    assign core_rst_n   = dom_rst_n[D_CORE];
    assign phy_rst_n    = dom_rst_n[D_PHY];
    assign sticky_rst_n = dom_rst_n[D_STICKY];

    rdc_strap_latch #(.W(STRAP_W), .MASK(RECAP_MASK)) u_straps (
        .clk         (clk),
        .arst_n      (pin_n),
        .link_exit_i (link_exit),
        .strap_i     (strap_in),
        .strap_o     (strap_q)
    );

    // Flag that is set by the warm pin and clears on the first edge after.
    always_ff @(posedge clk or negedge warm_n) begin
        if (!warm_n)
            warm_hold_q <= 1'b1;
        else
            warm_hold_q <= 1'b0;
    end

    // Pick the highest-numbered valid link request.
    always_comb begin
        link_pick = '0;
        for (int i = 0; i < NUM_LINK; i++)
            if (link_valid[i])
                link_pick = cause_t'(1) << (C_LINK0 + i);
    end

    // Cause register: power-on clears it to its own code, then it tracks events.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cause_q <= cause_t'(1) << C_POR;
        else if (warm_hold_q)
            cause_q <= cause_t'(1) << C_WARM;
        else if (link_valid != '0)
            cause_q <= link_pick;
    end

    assign rst_cause = cause_q;

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        sticky_rst_n |=> sticky_rst_n); // R4
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $countones(rst_cause) == 1); // R10
    AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!pin_n)
        (!(endpoint_mode && link_enable) && !link_any) |=> !link_any); // R6
endmodule

// File: tb/rst_domain_ctrl_tb.sv
// Bench for rst_domain_ctrl: sweeps every link source through every mode pair
// and several pulse lengths, then checks pin resets and cause priority.
module rst_domain_ctrl_tb;
    localparam int          CLK_P = 10;
    localparam int          SW    = 8;
    localparam logic [7:0]  MASK  = 8'h0F;
    localparam int          STR   = 16;

    logic       clk = 1'b0;
    logic       por_n, warm_n, em, le;
    logic [3:0] req;
    logic [7:0] strap;
    logic       core_rst_n, phy_rst_n, sticky_rst_n;
    logic [7:0] strap_q;
    logic [5:0] rst_cause;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_strap;
    logic [5:0] exp_cause;

    always #(CLK_P/2) clk = ~clk;

    rst_domain_ctrl #(.STRAP_W(SW), .RECAP_MASK(MASK), .STRETCH_CYC(STR)) u_dut (
        .clk           (clk),
        .por_n         (por_n),
        .warm_n        (warm_n),
        .link_hot_req  (req[0]),
        .link_loop_req (req[1]),
        .link_dis_req  (req[2]),
        .link_down_req (req[3]),
        .endpoint_mode (em),
        .link_enable   (le),
        .strap_in      (strap),
        .core_rst_n    (core_rst_n),
        .phy_rst_n     (phy_rst_n),
        .sticky_rst_n  (sticky_rst_n),
        .strap_q       (strap_q),
        .rst_cause     (rst_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a request on the given sources for len edges, then count low cycles.
    task automatic link_case(input logic [3:0] srcs, input int len,
                             output int c_core, output int c_phy, output int c_stk);
        c_core = 0; c_phy = 0; c_stk = 0;
        req = srcs;
        for (int i = 0; i < len + 26; i++) begin
            @(negedge clk);
            if (i == len - 1) req = 4'b0;
            if (!core_rst_n)   c_core++;
            if (!phy_rst_n)    c_phy++;
            if (!sticky_rst_n) c_stk++;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cc, cp, cs, idx;
        logic on;
        por_n = 1'b0; warm_n = 1'b1; req = 4'b0; em = 1'b1; le = 1'b1; strap = 8'hA5;
        repeat (4) @(negedge clk);
        chk("R1 core", core_rst_n, 0);
        chk("R1 phy", phy_rst_n, 0);
        chk("R1 sticky", sticky_rst_n, 0);
        chk("R1 cause", rst_cause, 6'b000001);
        strap = 8'h3C;
        por_n = 1'b1;
        @(negedge clk);
        chk("R3 core one edge after release", core_rst_n, 0);
        chk("R3 sticky one edge after release", sticky_rst_n, 0);
        @(negedge clk);
        chk("R3 core two edges", core_rst_n, 1);
        chk("R3 phy two edges", phy_rst_n, 1);
        chk("R3 sticky two edges", sticky_rst_n, 1);
        chk("R8 full strap after power-on", strap_q, 8'h3C);
        exp_strap = 8'h3C;
        exp_cause = 6'b000001;

        idx = 0;
        foreach (req[src]) begin
            for (int m = 0; m < 4; m++) begin
                for (int li = 0; li < 3; li++) begin
                    int len;
                    len = (li == 0) ? 1 : (li == 1) ? 2 : 5;
                    em = m[0];
                    le = m[1];
                    on = em & le;
                    strap = 8'((idx * 37 + 91) ^ (idx << 4));
                    idx++;
                    link_case(4'(1 << src), len, cc, cp, cs);
                    chk(on ? "R7 core low cycles" : "R6 core untouched",
                        cc, on ? len + STR : 0);
                    chk(src == 3 ? "R5 phy low cycles" : "R4 phy untouched",
                        cp, (on && src == 3) ? len + STR : 0);
                    chk("R4 sticky untouched", cs, 0);
                    if (on) begin
                        exp_strap = (exp_strap & ~MASK) | (strap & MASK);
                        exp_cause = 6'(1 << (2 + src));
                    end
                    chk(on ? "R9 masked recapture" : "R6 straps unchanged", strap_q, exp_strap);
                    chk(on ? "R10 link cause" : "R6 cause unchanged", rst_cause, exp_cause);
                end
            end
        end

        em = 1'b1; le = 1'b1;
        strap = 8'hF0;
        link_case(4'b1001, 1, cc, cp, cs);
        chk("R10 priority link down over hot", rst_cause, 6'b100000);
        chk("R5 phy low on joint request", cp, 1 + STR);
        chk("R9 joint recapture", strap_q, (exp_strap & ~MASK) | (8'hF0 & MASK));

        @(negedge clk);
        warm_n = 1'b0;
        strap = 8'h96;
        @(negedge clk);
        chk("R2 core during warm", core_rst_n, 0);
        chk("R2 phy during warm", phy_rst_n, 0);
        chk("R2 sticky during warm", sticky_rst_n, 1);
        repeat (2) @(negedge clk);
        warm_n = 1'b1;
        @(negedge clk);
        chk("R3 phy one edge after warm", phy_rst_n, 0);
        @(negedge clk);
        chk("R3 core two edges after warm", core_rst_n, 1);
        chk("R2 sticky after warm", sticky_rst_n, 1);
        chk("R8 full strap after warm", strap_q, 8'h96);
        chk("R10 warm cause", rst_cause, 6'b000010);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule